// File: doc/BRIEF.md
# Dual-Write-Port Register File

This block is a register array with two write ports and two read ports, for a datapath that retires two results in the same cycle. Each write port has its own address, enable and data word, and both commit on the rising clock edge. Each read port returns the addressed register combinationally.

For every register, the two gated write-address decoders each supply a select line. The register loads when either line is set. A per-register 2:1 multiplexer gives the second write port priority, so a same-register collision has a fixed winner. Register 0 is a hard-wired zero. A read in the same cycle as a write to the same register returns the old contents: there is no forwarding path, so any bypass must be built around the file.

The register count and word width are parameters. The count must be a power of two, and an elaboration-time check enforces this. A parameter also selects whether register 0 is a constant or an ordinary storage register.

Top module: `rf2w_regfile`

## Requirements
- R1: While reset (rst_n low, asynchronous) is held and after it is released, every register reads 0.
- R2: With w1_en high and w1_addr = k (k not 0), the value on w1_data at a rising edge is read back from k after that edge.
- R3: With w2_en high and w2_addr = k (k not 0), the value on w2_data at a rising edge is read back from k after that edge.
- R4: When both ports write different non-zero registers at the same edge, both registers take their own port's data.
- R5: When both ports write the same non-zero register at the same edge, the register holds w2_data.
- R6: Address 0 always reads 0 on both read ports. Writes to address 0 from either port leave it reading 0.
- R7: A register that neither enabled port addresses at an edge keeps its value. Data or addresses presented with the enable low change nothing.
- R8: A read of register k in a cycle that writes k returns the value stored before that edge. The new value appears only after the edge.
- R9: The two read ports are independent. Each returns its own addressed register, and equal read addresses give equal data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all writes |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| w1_en | input | 1 | Write enable, port 1 |
| w1_addr | input | 5 | Target register, port 1 |
| w1_data | input | 32 | Write data, port 1 |
| w2_en | input | 1 | Write enable, port 2 (wins collisions) |
| w2_addr | input | 5 | Target register, port 2 |
| w2_data | input | 32 | Write data, port 2 |
| r1_addr | input | 5 | Read address, port 1 |
| r1_data | output | 32 | Read data, port 1 (combinational) |
| r2_addr | input | 5 | Read address, port 2 |
| r2_data | output | 32 | Read data, port 2 (combinational) |

## Verification
The write-to-read properties assume the inputs are held stable across each rising edge. They also assume the read address one cycle after a write may or may not match the written register, so each property constrains only the cycles where the addresses line up. The bench meets these assumptions by changing every input at the falling edge only. It crowds the random addresses into a few low registers, including 0, so that collisions, writes to register 0 and read-after-write matches occur often. It also includes directed cycles that read a register in the same cycle it is written.

// File: rtl/rf2w_pkg.sv
package rf2w_pkg;
   localparam int RF_REGS_DEFAULT = 32;
   localparam int RF_WIDTH_DEFAULT = 32;

   typedef enum logic {
      SRC_PORT1 = 1'b0,
      SRC_PORT2 = 1'b1
   } rf_src_e;

   function automatic rf_src_e pick_source(input logic sel2);
      return sel2 ? SRC_PORT2 : SRC_PORT1;
   endfunction
endpackage

// File: rtl/rf2w_decoder.sv
module rf2w_decoder #(
   parameter int NUM_REGS = 32,
   parameter int LO_INDEX = 1,
   localparam int ADDR_W = $clog2(NUM_REGS)
) (
   input  logic                       en,
   input  logic [ADDR_W-1:0]          addr,
   output logic [NUM_REGS-1:LO_INDEX] hit
);
   for (genvar i = LO_INDEX; i < NUM_REGS; i++) begin : g_line
      assign hit[i] = en && (addr == ADDR_W'(i));
   end
endmodule

// File: rtl/rf2w_cell.sv
module rf2w_cell
   import rf2w_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel1,
   input  logic              sel2,
   input  logic [DATA_W-1:0] d1,
   input  logic [DATA_W-1:0] d2,
   output logic [DATA_W-1:0] q
);
   logic              load;
   rf_src_e           src;
   logic [DATA_W-1:0] next_d;

   assign load = sel1 | sel2;
   assign src  = pick_source(sel2);

   always_comb begin
      unique case (src)
         SRC_PORT2: next_d = d2;
         default:   next_d = d1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= next_d;
   end
endmodule

// File: rtl/rf2w_rdport.sv
module rf2w_rdport #(
   parameter int NUM_REGS = 32,
   parameter int DATA_W = 32,
   localparam int ADDR_W = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
   input  logic [ADDR_W-1:0]               addr,
   output logic [DATA_W-1:0]               data
);
   assign data = regs[addr];
endmodule

// File: rtl/rf2w_regfile.sv
module rf2w_regfile
   import rf2w_pkg::*;
#(
   parameter int NUM_REGS = RF_REGS_DEFAULT,
   parameter int DATA_W = RF_WIDTH_DEFAULT,
   parameter bit ZERO_REG = 1'b1,
   localparam int ADDR_W = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              w1_en,
   input  logic [ADDR_W-1:0] w1_addr,
   input  logic [DATA_W-1:0] w1_data,
   input  logic              w2_en,
   input  logic [ADDR_W-1:0] w2_addr,
   input  logic [DATA_W-1:0] w2_data,
   input  logic [ADDR_W-1:0] r1_addr,
   output logic [DATA_W-1:0] r1_data,
   input  logic [ADDR_W-1:0] r2_addr,
   output logic [DATA_W-1:0] r2_data
);
   localparam int LO_INDEX = ZERO_REG ? 1 : 0;

   if (NUM_REGS < 2 || (1 << ADDR_W) != NUM_REGS) begin : g_bad_count
      $error("rf2w_regfile: NUM_REGS must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rf2w_regfile: DATA_W must be positive");
   end

   logic [NUM_REGS-1:LO_INDEX]      hit1;
   logic [NUM_REGS-1:LO_INDEX]      hit2;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs;

   rf2w_decoder #(.NUM_REGS(NUM_REGS), .LO_INDEX(LO_INDEX)) u_dec1 (
      .en(w1_en), .addr(w1_addr), .hit(hit1)
   );
   rf2w_decoder #(.NUM_REGS(NUM_REGS), .LO_INDEX(LO_INDEX)) u_dec2 (
      .en(w2_en), .addr(w2_addr), .hit(hit2)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (ZERO_REG && i == 0) begin : g_const
         assign regs[i] = '0;
      end else begin : g_store
         rf2w_cell #(.DATA_W(DATA_W)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .sel1(hit1[i]), .sel2(hit2[i]),
            .d1(w1_data), .d2(w2_data),
            .q(regs[i])
         );
      end
   end

   rf2w_rdport #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd1 (
      .regs(regs), .addr(r1_addr), .data(r1_data)
   );
   rf2w_rdport #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd2 (
      .regs(regs), .addr(r2_addr), .data(r2_data)
   );
endmodule

// File: rtl/rf2w_checker.sv
module rf2w_checker #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32,
   parameter bit ZERO_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              w1_en,
   input logic [ADDR_W-1:0] w1_addr,
   input logic [DATA_W-1:0] w1_data,
   input logic              w2_en,
   input logic [ADDR_W-1:0] w2_addr,
   input logic [DATA_W-1:0] w2_data,
   input logic [ADDR_W-1:0] r1_addr,
   input logic [DATA_W-1:0] r1_data,
   input logic [ADDR_W-1:0] r2_addr,
   input logic [DATA_W-1:0] r2_data
);
   if (ZERO_REG) begin : g_zero
      AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
         (r1_addr == '0) |-> (r1_data == '0)); // R6
   end

   AST_SAME_ADDR_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (r1_addr == r2_addr) |-> (r1_data == r2_data)); // R9

   AST_PORT1_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(w1_en) && ($past(w1_addr) != '0 || !ZERO_REG)
       && !($past(w2_en) && $past(w2_addr) == $past(w1_addr))
       && r1_addr == $past(w1_addr))
      |-> (r1_data == $past(w1_data))); // R2

   AST_PORT2_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(w2_en) && ($past(w2_addr) != '0 || !ZERO_REG)
       && !($past(w1_en) && $past(w1_addr) == $past(w2_addr))
       && r2_addr == $past(w2_addr))
      |-> (r2_data == $past(w2_data))); // R3

   AST_COLLISION_PORT2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(w1_en) && $past(w2_en)
       && $past(w1_addr) == $past(w2_addr)
       && ($past(w2_addr) != '0 || !ZERO_REG)
       && r1_addr == $past(w2_addr))
      |-> (r1_data == $past(w2_data))); // R5

   AST_HOLD_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(r1_addr)
       && !($past(w1_en) && $past(w1_addr) == r1_addr)
       && !($past(w2_en) && $past(w2_addr) == r1_addr))
      |-> $stable(r1_data)); // R7
endmodule

bind rf2w_regfile rf2w_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ZERO_REG(ZERO_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .w1_en(w1_en), .w1_addr(w1_addr), .w1_data(w1_data),
   .w2_en(w2_en), .w2_addr(w2_addr), .w2_data(w2_data),
   .r1_addr(r1_addr), .r1_data(r1_data),
   .r2_addr(r2_addr), .r2_data(r2_data)
);

// File: tb/tb_rf2w_regfile.sv
module tb_rf2w_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        w1_en = 1'b0, w2_en = 1'b0;
   logic [4:0]  w1_addr = '0, w2_addr = '0, r1_addr = '0, r2_addr = '0;
   logic [31:0] w1_data = '0, w2_data = '0;
   logic [31:0] r1_data, r2_data;

   int unsigned model [32];
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rf2w_regfile dut (
      .clk(clk), .rst_n(rst_n),
      .w1_en(w1_en), .w1_addr(w1_addr), .w1_data(w1_data),
      .w2_en(w2_en), .w2_addr(w2_addr), .w2_data(w2_data),
      .r1_addr(r1_addr), .r1_data(r1_data),
      .r2_addr(r2_addr), .r2_data(r2_data)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   // One clock: drive at the falling edge, compare reads against the
   // pre-edge model, then commit the writes to the model after the edge.
   task automatic cyc(input logic e1, input logic [4:0] a1, input logic [31:0] d1,
                      input logic e2, input logic [4:0] a2, input logic [31:0] d2,
                      input logic [4:0] ra, input logic [4:0] rb, input string tag);
      @(negedge clk);
      w1_en = e1; w1_addr = a1; w1_data = d1;
      w2_en = e2; w2_addr = a2; w2_data = d2;
      r1_addr = ra; r2_addr = rb;
      #1;
      check({tag, " rd1"}, r1_data, model[ra]);
      check({tag, " rd2"}, r2_data, model[rb]);
      @(posedge clk);
      #1;
      if (e1 && a1 != 0) model[a1] = d1;
      if (e2 && a2 != 0) model[a2] = d2;
   endtask

   task automatic rd(input logic [4:0] ra, input logic [4:0] rb, input string tag);
      cyc(1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 32'h0, ra, rb, tag);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) model[i] = 0;
      // R1: values during reset, with write attempts ignored
      repeat (2) @(negedge clk);
      w1_en = 1'b1; w1_addr = 5'd3; w1_data = 32'hdead_beef;
      r1_addr = 5'd3; r2_addr = 5'd31;
      @(negedge clk); #1;
      check("R1 during reset rd1", r1_data, 32'h0);
      check("R1 during reset rd2", r2_data, 32'h0);
      w1_en = 1'b0;
      rst_n = 1'b1;
      for (int i = 0; i < 32; i += 2) rd(5'(i), 5'(i + 1), "R1 after reset");

      // R2 and R3: single-port writes
      cyc(1, 5'd4, 32'h1111_0004, 0, 5'd0, 32'h0, 5'd0, 5'd0, "R2 write");
      rd(5'd4, 5'd4, "R2 readback");
      cyc(0, 5'd0, 32'h0, 1, 5'd9, 32'h2222_0009, 5'd0, 5'd0, "R3 write");
      rd(5'd9, 5'd4, "R3 readback");
      // R4: both ports, different registers
      cyc(1, 5'd12, 32'haaaa_000c, 1, 5'd13, 32'hbbbb_000d, 5'd1, 5'd2, "R4 write");
      rd(5'd12, 5'd13, "R4 readback");
      // R5: collision, port 2 wins
      cyc(1, 5'd20, 32'h5555_5555, 1, 5'd20, 32'h6666_6666, 5'd20, 5'd20, "R5 write");
      rd(5'd20, 5'd20, "R5 readback");
      // R6: register 0 from both ports, including a collision
      cyc(1, 5'd0, 32'hffff_ffff, 0, 5'd0, 32'h0, 5'd0, 5'd0, "R6 write p1");
      cyc(0, 5'd0, 32'h0, 1, 5'd0, 32'h1234_5678, 5'd0, 5'd0, "R6 write p2");
      cyc(1, 5'd0, 32'h0f0f_0f0f, 1, 5'd0, 32'hf0f0_f0f0, 5'd0, 5'd0, "R6 write both");
      rd(5'd0, 5'd0, "R6 readback");
      // R7: enable low leaves target unchanged
      cyc(0, 5'd4, 32'h7777_7777, 0, 5'd9, 32'h8888_8888, 5'd4, 5'd9, "R7 disabled");
      rd(5'd4, 5'd9, "R7 readback");
      // R8: same-cycle read sees the old value (model not yet committed)
      cyc(1, 5'd4, 32'hcafe_0004, 1, 5'd9, 32'hcafe_0009, 5'd4, 5'd9, "R8 old value");
      rd(5'd4, 5'd9, "R8 new value");
      // R9: independent read ports on distinct registers
      rd(5'd12, 5'd20, "R9 distinct");
      rd(5'd20, 5'd12, "R9 swapped");

      // Random traffic crowded into a few registers for collisions
      for (int n = 0; n < 3000; n++) begin
         logic [4:0] a1, a2, ra, rb;
         a1 = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'($urandom_range(0, 5));
         a2 = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'($urandom_range(0, 5));
         ra = ($urandom_range(0, 1) == 0) ? a1 : 5'($urandom_range(0, 5));
         rb = ($urandom_range(0, 1) == 0) ? a2 : 5'($urandom);
         cyc(1'($urandom), a1, $urandom, 1'($urandom), a2, $urandom, ra, rb,
             "R5 random dual write");
      end
      for (int i = 0; i < 32; i += 2) rd(5'(i), 5'(i + 1), "R4 final sweep");

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end
endmodule